// File: doc/BRIEF.md
# Event Store Writer for Byte-Wide Asynchronous SRAM

This block drains a first-word-fall-through event FIFO into an external asynchronous SRAM whose data bus is only one byte wide. Each event popped from the FIFO is split into byte lanes. The lanes are written to the SRAM one after another, least-significant lane first, at linearly increasing byte addresses starting from zero.

Every byte write is a three-phase cycle. In the setup clock, address and data settle with chip-enable active. Then the write strobe is held low for a programmable number of clocks. A final hold clock keeps address and data unchanged. The strobe width is chosen so that a slow SRAM with a 70 to 100 ns access time is met at the capture clock rate.

When the byte at the highest SRAM address has been written, a sticky full flag rises and no further FIFO entries are taken. A running count of completed events is exported so that a later readout stage knows how much of the memory is valid.

Top module: `evtSramWriter`

## Requirements
- R1: After reset, sramWeN and sramCeN are 1, fifoPop is 0, sramAddr is 0, evtCount is 0 and memFull is 0.
- R2: fifoPop is a single-cycle pulse. It is raised only while the writer is idle, fifoEmpty is 0 and memFull is 0. The event on fifoData is captured in that same cycle. There is exactly one pop per stored event.
- R3: Each event (default 32 bits, 8-bit bytes) is written as four byte writes. Bits [7:0] go first, then [15:8], [23:16] and [31:24], at four consecutive addresses.
- R4: For every byte write, sramWeN is low for exactly PULSE_CYC consecutive clocks (default 4).
- R5: During the clock before sramWeN falls, all clocks it is low, and the clock after it rises, sramCeN is 0 and sramAddr and sramData do not change.
- R6: Byte addresses start at 0 and advance by exactly one after each byte write.
- R7: evtCount increments by one when the last byte of an event has been written.
- R8: When the byte at the all-ones address has been written, memFull becomes 1 and stays 1. sramAddr stays at the all-ones address, and no further pop or write occurs even though the FIFO is not empty.
- R9: While the FIFO is empty, sramCeN stays 1 and no write strobe occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEmpty | input | 1 | Event FIFO has no entry |
| fifoData | input | EVT_W | Head entry of the event FIFO (fall-through) |
| fifoPop | output | 1 | Removes the head entry from the FIFO |
| sramAddr | output | ADDR_W | SRAM byte address |
| sramData | output | BYTE_W | SRAM write data |
| sramWeN | output | 1 | SRAM write enable, active low |
| sramCeN | output | 1 | SRAM chip enable, active low |
| memFull | output | 1 | Sticky flag: last SRAM byte written |
| evtCount | output | ADDR_W-log2(EVT_W/BYTE_W)+1 | Number of events stored |

## Verification
The delicate cycle is the end of the hold phase of the final byte in memory. In that same clock edge the full flag is set, the event count steps, and the control returns to idle, where the pop decision is made while the FIFO still holds entries. The bench provokes this by loading more events than the shrunken memory (64 bytes) can accept. It then judges that exactly the fitting events were popped and stored, that the surplus stays in the FIFO over a long idle stretch, and that the address remains pinned at the top.

// File: rtl/evtw_pkg.sv
package evtw_pkg;
  localparam int SEL_BITS = 4;

  typedef struct packed {
    logic                loadEvt;
    logic                advByte;
    logic                finishEvt;
    logic [SEL_BITS-1:0] byteSel;
  } wrStrobe_t;
endpackage

// File: rtl/evtw_ctrl.sv
module evtw_ctrl
  import evtw_pkg::*;
#(
  parameter int PULSE_CYC = 4,
  parameter int NBYTES    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoEmpty,
  input  logic       memFull,
  output logic       fifoPop,
  output wrStrobe_t  ctl,
  output logic       weN,
  output logic       ceN
);
  localparam int PCW = $clog2(PULSE_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD} wrState_e;

  wrState_e            state;
  logic [PCW-1:0]      pulseCnt;
  logic [SEL_BITS-1:0] byteCnt;
  logic                lastByte;

  assign lastByte = (byteCnt == SEL_BITS'(NBYTES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pulseCnt <= '0;
      byteCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          byteCnt <= '0;
          if (!fifoEmpty && !memFull) state <= ST_SETUP;
        end
        ST_SETUP: begin
          pulseCnt <= '0;
          state    <= ST_STROBE;
        end
        ST_STROBE: begin
          if (pulseCnt == PCW'(PULSE_CYC - 1)) state <= ST_HOLD;
          else pulseCnt <= pulseCnt + 1'b1;
        end
        default: begin
          if (lastByte) state <= ST_IDLE;
          else begin
            byteCnt <= byteCnt + 1'b1;
            state   <= ST_SETUP;
          end
        end
      endcase
    end
  end

  always_comb begin
    fifoPop       = (state == ST_IDLE) && !fifoEmpty && !memFull;
    ctl.loadEvt   = fifoPop;
    ctl.advByte   = (state == ST_HOLD);
    ctl.finishEvt = (state == ST_HOLD) && lastByte;
    ctl.byteSel   = byteCnt;
    weN           = (state != ST_STROBE);
    ceN           = (state == ST_IDLE);
  end

  // R2: a pop needs a non-empty FIFO and free memory
  p_pop_guard_r2: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (!fifoEmpty && !memFull));

  // R2: never two pops in a row
  p_pop_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> !fifoPop);
endmodule

// File: rtl/evtw_datapath.sv
module evtw_datapath
  import evtw_pkg::*;
#(
  parameter int EVT_W  = 32,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 17
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           ctl,
  input  logic [EVT_W-1:0]    evtIn,
  output logic [ADDR_W-1:0]   addr,
  output logic [BYTE_W-1:0]   dataOut,
  output logic                full,
  output logic [ADDR_W-$clog2(EVT_W/BYTE_W):0] count
);
  localparam int NBYTES = EVT_W / BYTE_W;
  localparam int CNT_W  = ADDR_W - $clog2(NBYTES) + 1;
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

  logic [EVT_W-1:0]  evtReg;
  logic [BYTE_W-1:0] lane [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lane[g] = evtReg[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    dataOut = lane[0];
    for (int i = 1; i < NBYTES; i++)
      if (ctl.byteSel == SEL_BITS'(i)) dataOut = lane[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtReg <= '0;
      addr   <= '0;
      full   <= 1'b0;
      count  <= '0;
    end else begin
      if (ctl.loadEvt) evtReg <= evtIn;
      if (ctl.advByte) begin
        if (addr == ADDR_LAST) full <= 1'b1;
        else addr <= addr + 1'b1;
      end
      if (ctl.finishEvt) count <= count + CNT_W'(1);
    end
  end

  // R8: full flag never clears
  p_full_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    full |=> full);

  // R6: one address step per byte below the top
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advByte && addr != ADDR_LAST) |=> addr == $past(addr) + 1'b1);

  // R7: count steps exactly on event completion
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finishEvt |=> count == $past(count) + CNT_W'(1));
endmodule

// File: rtl/evtSramWriter.sv
module evtSramWriter
  import evtw_pkg::*;
#(
  parameter int EVT_W     = 32,
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = 17,
  parameter int PULSE_CYC = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fifoEmpty,
  input  logic [EVT_W-1:0]    fifoData,
  output logic                fifoPop,
  output logic [ADDR_W-1:0]   sramAddr,
  output logic [BYTE_W-1:0]   sramData,
  output logic                sramWeN,
  output logic                sramCeN,
  output logic                memFull,
  output logic [ADDR_W-$clog2(EVT_W/BYTE_W):0] evtCount
);
  localparam int NBYTES = EVT_W / BYTE_W;
  localparam int WCW    = $clog2(PULSE_CYC + 2) + 1;

  wrStrobe_t ctl;

  evtw_ctrl #(.PULSE_CYC(PULSE_CYC), .NBYTES(NBYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .memFull(memFull),
    .fifoPop(fifoPop), .ctl(ctl), .weN(sramWeN), .ceN(sramCeN)
  );

  evtw_datapath #(.EVT_W(EVT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .evtIn(fifoData),
    .addr(sramAddr), .dataOut(sramData), .full(memFull), .count(evtCount)
  );

  // strobe-width observer for the checks below
  logic [WCW-1:0] weLowCnt;
  always_ff @(posedge clk) begin
    if (!rstN) weLowCnt <= '0;
    else if (!sramWeN) weLowCnt <= weLowCnt + 1'b1;
    else weLowCnt <= '0;
  end

  // R4: strobe lasts exactly PULSE_CYC clocks
  p_we_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> weLowCnt == WCW'(PULSE_CYC));

  // R5: setup clock before the strobe
  p_setup_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramWeN) |-> ($stable(sramAddr) && $stable(sramData) && !sramCeN && $past(!sramCeN)));

  // R5: stable throughout the strobe
  p_strobe_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!sramWeN && $past(!sramWeN)) |-> ($stable(sramAddr) && $stable(sramData)));

  // R5: hold clock after the strobe
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> ($stable(sramAddr) && $stable(sramData) && !sramCeN));

  // R8: no pop once memory is full
  p_no_pop_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    memFull |-> !fifoPop);
endmodule

// File: tb/sim_evtSramWriter.sv
`timescale 1ns/1ps
module sim_evtSramWriter;
  localparam int AW       = 6;
  localparam int NB       = 1 << AW;
  localparam int PULSE    = 4;
  localparam int CW       = AW - 2 + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          fifoEmpty;
  logic [31:0]   fifoData;
  logic          fifoPop;
  logic [AW-1:0] sramAddr;
  logic [7:0]    sramData;
  logic          sramWeN, sramCeN, memFull;
  logic [CW-1:0] evtCount;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] fq [64];
  int wrPtr = 0;
  int rdPtr = 0;
  int popCnt = 0;

  logic [7:0] mem [NB];
  int writes = 0;
  int expAddr = 0;

  always #4 clk = ~clk;

  assign fifoEmpty = (rdPtr == wrPtr);
  assign fifoData  = fq[rdPtr % 64];

  evtSramWriter #(.EVT_W(32), .BYTE_W(8), .ADDR_W(AW), .PULSE_CYC(PULSE)) u0 (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .fifoData(fifoData),
    .fifoPop(fifoPop), .sramAddr(sramAddr), .sramData(sramData),
    .sramWeN(sramWeN), .sramCeN(sramCeN), .memFull(memFull), .evtCount(evtCount)
  );

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // behavioural FIFO read side
  always @(posedge clk) if (rstN && fifoPop) begin
    rdPtr <= rdPtr + 1;
    popCnt <= popCnt + 1;
  end

  // behavioural SRAM and interface monitor
  logic          prevWe = 1'b1, prevCe = 1'b1;
  logic [AW-1:0] prevAddr = '0;
  logic [7:0]    prevData = '0;
  int            lowCnt = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (fifoPop && fifoEmpty) check("R2 pop on empty", 0, 1, 0);
      if (fifoPop && memFull)   check("R8 pop when full", 0, 1, 0);
      if (prevWe && !sramWeN)
        check("R5 setup", !prevCe && prevAddr == sramAddr && prevData == sramData,
              {prevCe, prevAddr}, {1'b0, sramAddr});
      if (!prevWe && !sramWeN)
        check("R5 strobe stable", prevAddr == sramAddr && prevData == sramData && !sramCeN,
              sramData, prevData);
      if (!prevWe && sramWeN) begin
        check("R4 strobe width", lowCnt == PULSE, lowCnt, PULSE);
        check("R5 hold", !sramCeN && prevAddr == sramAddr && prevData == sramData,
              sramAddr, prevAddr);
        check("R6 address sequence", int'(sramAddr) == expAddr, sramAddr, expAddr);
        mem[sramAddr] = sramData;
        writes++;
        expAddr++;
      end
      lowCnt = sramWeN ? 0 : lowCnt + 1;
    end
    prevWe = sramWeN; prevCe = sramCeN; prevAddr = sramAddr; prevData = sramData;
  end

  task automatic push(input logic [31:0] v);
    fq[wrPtr % 64] = v;
    wrPtr++;
  endtask

  task automatic waitIdle();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(sramCeN && (fifoEmpty || memFull)) && n < 3000);
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 weN", sramWeN === 1'b1, sramWeN, 1);
    check("R1 ceN", sramCeN === 1'b1, sramCeN, 1);
    check("R1 pop", fifoPop === 1'b0, fifoPop, 0);
    check("R1 addr", sramAddr === '0, sramAddr, 0);
    check("R1 count", evtCount === '0, evtCount, 0);
    check("R1 full", memFull === 1'b0, memFull, 0);
  endtask

  task automatic testSingle();
    @(negedge clk);
    push(32'h4433_2211);
    waitIdle();
    check("R3 byte0", mem[0] == 8'h11, mem[0], 8'h11);
    check("R3 byte1", mem[1] == 8'h22, mem[1], 8'h22);
    check("R3 byte2", mem[2] == 8'h33, mem[2], 8'h33);
    check("R3 byte3", mem[3] == 8'h44, mem[3], 8'h44);
    check("R7 count one", evtCount == 1, evtCount, 1);
    check("R6 next addr", sramAddr == 4, sramAddr, 4);
    check("R2 one pop", popCnt == 1, popCnt, 1);
  endtask

  task automatic testBurst();
    @(negedge clk);
    push(32'hA0B0C0D0); push(32'h0102_0304); push(32'hFFEE_0080);
    waitIdle();
    check("R3 burst e1", {mem[7], mem[6], mem[5], mem[4]} == 32'hA0B0C0D0,
          {mem[7], mem[6], mem[5], mem[4]}, 32'hA0B0C0D0);
    check("R3 burst e2", {mem[11], mem[10], mem[9], mem[8]} == 32'h01020304,
          {mem[11], mem[10], mem[9], mem[8]}, 32'h01020304);
    check("R3 burst e3", {mem[15], mem[14], mem[13], mem[12]} == 32'hFFEE0080,
          {mem[15], mem[14], mem[13], mem[12]}, 32'hFFEE0080);
    check("R7 count four", evtCount == 4, evtCount, 4);
    check("R2 pops four", popCnt == 4, popCnt, 4);
  endtask

  task automatic testIdle();
    int w0 = writes;
    bit ceHigh = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!sramCeN || !sramWeN) ceHigh = 0;
    end
    check("R9 idle ceN/weN high", ceHigh, !ceHigh, 0);
    check("R9 no writes", writes == w0, writes, w0);
  endtask

  task automatic testFull();
    int leftover;
    @(negedge clk);
    for (int i = 0; i < 14; i++) push(32'h5000_0000 + i * 32'h0101_0101);
    waitIdle();
    repeat (60) @(negedge clk);
    leftover = wrPtr - rdPtr;
    check("R8 full flag", memFull == 1'b1, memFull, 1);
    check("R8 count 16", evtCount == 16, evtCount, 16);
    check("R8 leftover", leftover == 2, leftover, 2);
    check("R8 addr pinned", sramAddr == NB - 1, sramAddr, NB - 1);
    check("R8 writes 64", writes == NB, writes, NB);
    check("R8 idle after full", sramCeN == 1'b1, sramCeN, 1);
    for (int i = 0; i < 12; i++) begin
      logic [31:0] e = 32'h5000_0000 + i * 32'h0101_0101;
      int b = 16 + 4 * i;
      check("R3 filled event", {mem[b+3], mem[b+2], mem[b+1], mem[b]} == e,
            {mem[b+3], mem[b+2], mem[b+1], mem[b]}, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingle();
    testBurst();
    testIdle();
    testFull();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule